// File: doc/BRIEF.md
# Coprocessor Control and Semaphore Registers

This block holds the control state of a vector coprocessor: a status word with a halt flag, a break flag, a single-step flag, an interrupt-on-break enable and eight general-purpose signal flags. It also keeps an interrupt request line and a one-bit hardware semaphore. Software never writes the status bits directly. Each write carries command bits that set or clear individual flags. A conflicting command for one flag leaves that flag alone.

The core pipeline reports a break instruction with a one-cycle pulse. The pulse halts the core, marks the break, and raises the interrupt when the enable allows it. The semaphore gives mutual exclusion between the host and the coprocessor. A read claims it and returns its previous value, so a returned 0 means the reader now holds it. Any write releases it. Register reads are combinational in the cycle `rd_en_i` is high, and all state updates take effect at the next rising clock edge.

Top module: `cop_ctrl_regs`

## Requirements
- R1: After reset the status read (address 0) returns 0x0001, the semaphore reads 0, `irq_o` is 0 and `halt_o` is 1.
- R2: In a status write (address 0), a flag with a clear/set command pair becomes 1 when only its set bit is 1 and becomes 0 when only its clear bit is 1. The pairs are (clear bit, set bit): halt (0,1), single-step (5,6), interrupt-on-break (7,8), signal k (9+2k, 10+2k) for k = 0..7.
- R3: A flag whose clear bit and set bit are both 1, or both 0, keeps its value after a status write.
- R4: Write bit 2 set to 1 clears the break flag, whatever the other bits of the word are. Break has no software set command.
- R5: The interrupt line follows the same pair rule, with clear at write bit 3 and set at write bit 4.
- R6: A cycle with `brk_pulse_i` high sets both the break flag and the halt flag. If interrupt-on-break is 1 in that cycle, `irq_o` is also set.
- R7: When a break pulse and a status write arrive in the same cycle, halt and break end up 1. The other flags follow the write. A raise of the interrupt by the pulse wins over a clear in the same write.
- R8: A read of address 1 returns the semaphore in bit 0 and leaves the semaphore at 1 from the next cycle on.
- R9: A write to address 1 with any data clears the semaphore. If the same cycle also has a read there, the clear wins.
- R10: `halt_o` always equals status bit 0.
- R11: The status read has halt at bit 0, break at bit 1, single-step at bit 5, interrupt-on-break at bit 6 and signal k at bit 7+k. All other bits read 0. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (2) | Register address: 0 status, 1 semaphore |
| wdata_i | input | DATA_W (32) | Write command word |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a semaphore read claims it |
| rdata_o | output | DATA_W (32) | Read data, valid while rd_en_i is high, else 0 |
| brk_pulse_i | input | 1 | Break event from the core pipeline |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Core halt |

## Verification
Every piece of state in this block can be seen at the ports within one cycle. A wrong flag appears in the next status read, or on `irq_o` or `halt_o` right after the edge that updated it. A decode slip, such as a swapped clear/set position or a missed conflict case, therefore shows up in the first read after the offending write. A semaphore that fails to claim shows up as a second read returning 0. The sweeps drive every command pair through all four encodings from both starting values. Long pseudo-random command streams, with some break pulses mixed in, catch interactions between fields.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;

    localparam int SIG_N    = 8;
    // paired flags: halt, irq, single-step, break-irq enable, signals
    localparam int PAIR_N   = 4 + SIG_N;
    localparam int PI_HALT  = 0;
    localparam int PI_IRQ   = 1;
    localparam int PI_SSTEP = 2;
    localparam int PI_IBRK  = 3;
    localparam int PI_SIG0  = 4;

    // write-word layout
    localparam int WB_BRK_CLR = 2;
    localparam int WB_TOP     = 10 + 2 * (SIG_N - 1);

    // read-word layout
    localparam int RB_HALT  = 0;
    localparam int RB_BRK   = 1;
    localparam int RB_SSTEP = 5;
    localparam int RB_IBRK  = 6;
    localparam int RB_SIG0  = 7;

    typedef struct packed {
        logic             halt;
        logic             brk;
        logic             sstep;
        logic             ibrk;
        logic [SIG_N-1:0] sig;
        logic             irq;
        logic             sema;
    } ctrl_state_t;

    // clear-bit position of paired flag idx; its set bit is one above
    function automatic int pair_clr_pos(input int idx);
        if (idx == PI_HALT) return 0;
        if (idx == PI_IRQ)  return 3;
        return 5 + 2 * (idx - PI_SSTEP);
    endfunction

endpackage

// File: rtl/cop_pair_cmd.sv
module cop_pair_cmd #(
    parameter int N = 4
) (
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] nxt_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            unique case ({set_i[g], clr_i[g]})
                2'b10:   nxt_o[g] = 1'b1;
                2'b01:   nxt_o[g] = 1'b0;
                default: nxt_o[g] = cur_i[g];
            endcase
        end
    end
endmodule

// File: rtl/cop_sema_unit.sv
module cop_sema_unit (
    input  logic cur_i,
    input  logic claim_i,
    input  logic rel_i,
    output logic nxt_o
);
    always_comb begin
        if (rel_i)
            nxt_o = 1'b0;
        else if (claim_i)
            nxt_o = 1'b1;
        else
            nxt_o = cur_i;
    end
endmodule

// File: rtl/cop_read_mux.sv
module cop_read_mux
    import cop_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int STAT_ADDR = 0,
    parameter int SEMA_ADDR = 1
) (
    input  ctrl_state_t       st_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word           = '0;
        stat_word[RB_HALT]  = st_i.halt;
        stat_word[RB_BRK]   = st_i.brk;
        stat_word[RB_SSTEP] = st_i.sstep;
        stat_word[RB_IBRK]  = st_i.ibrk;
        for (int k = 0; k < SIG_N; k++)
            stat_word[RB_SIG0 + k] = st_i.sig[k];
    end

    always_comb begin
        word_o = '0;
        if (rd_en_i) begin
            if (addr_i == ADDR_W'(STAT_ADDR))
                word_o = stat_word;
            else if (addr_i == ADDR_W'(SEMA_ADDR))
                word_o[0] = st_i.sema;
        end
    end
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
    import cop_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int STAT_ADDR = 0,
    parameter int SEMA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              brk_pulse_i,
    output logic              irq_o,
    output logic              halt_o
);
    localparam ctrl_state_t RESET_ST = '{halt: 1'b1, default: '0};

    ctrl_state_t       state_d, state_q;
    logic              wr_stat, wr_sema, rd_sema;
    logic [PAIR_N-1:0] pair_cur, pair_clr, pair_set, pair_nxt;
    logic              sema_nxt;
    logic              unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:WB_TOP+1];

    assign wr_stat = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR));
    assign wr_sema = wr_en_i && (addr_i == ADDR_W'(SEMA_ADDR));
    assign rd_sema = rd_en_i && (addr_i == ADDR_W'(SEMA_ADDR));

    // command decode for every paired flag
    for (genvar g = 0; g < PAIR_N; g++) begin : g_dec
        localparam int CP = pair_clr_pos(g);
        assign pair_clr[g] = wr_stat && wdata_i[CP];
        assign pair_set[g] = wr_stat && wdata_i[CP + 1];
    end

    always_comb begin
        pair_cur           = '0;
        pair_cur[PI_HALT]  = state_q.halt;
        pair_cur[PI_IRQ]   = state_q.irq;
        pair_cur[PI_SSTEP] = state_q.sstep;
        pair_cur[PI_IBRK]  = state_q.ibrk;
        for (int k = 0; k < SIG_N; k++)
            pair_cur[PI_SIG0 + k] = state_q.sig[k];
    end

    cop_pair_cmd #(.N(PAIR_N)) u_pairs (
        .cur_i (pair_cur),
        .clr_i (pair_clr),
        .set_i (pair_set),
        .nxt_o (pair_nxt)
    );

    cop_sema_unit u_sema (
        .cur_i   (state_q.sema),
        .claim_i (rd_sema),
        .rel_i   (wr_sema),
        .nxt_o   (sema_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.halt  = pair_nxt[PI_HALT];
        state_d.irq   = pair_nxt[PI_IRQ];
        state_d.sstep = pair_nxt[PI_SSTEP];
        state_d.ibrk  = pair_nxt[PI_IBRK];
        for (int k = 0; k < SIG_N; k++)
            state_d.sig[k] = pair_nxt[PI_SIG0 + k];
        if (wr_stat && wdata_i[WB_BRK_CLR])
            state_d.brk = 1'b0;
        // core break event overrides software for halt/break/irq raise
        if (brk_pulse_i) begin
            state_d.halt = 1'b1;
            state_d.brk  = 1'b1;
            if (state_q.ibrk)
                state_d.irq = 1'b1;
        end
        state_d.sema = sema_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RESET_ST;
        else
            state_q <= state_d;
    end

    cop_read_mux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STAT_ADDR (STAT_ADDR),
        .SEMA_ADDR (SEMA_ADDR)
    ) u_rmux (
        .st_i    (state_q),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .word_o  (rdata_o)
    );

    assign irq_o  = state_q.irq;
    assign halt_o = state_q.halt;
endmodule

// File: rtl/cop_ctrl_regs_chk.sv
module cop_ctrl_regs_chk #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int STAT_ADDR = 0,
    parameter int SEMA_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              brk_pulse_i,
    input logic              irq_o,
    input logic              halt_o,
    input logic              ibrk_q,
    input logic              sema_q
);
    logic wr_stat, wr_sema, rd_sema;
    assign wr_stat = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR));
    assign wr_sema = wr_en_i && (addr_i == ADDR_W'(SEMA_ADDR));
    assign rd_sema = rd_en_i && (addr_i == ADDR_W'(SEMA_ADDR));

    p_halt_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(STAT_ADDR)) |-> (rdata_o[0] == halt_o));

    p_brk_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse_i |=> halt_o);

    p_brk_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pulse_i && ibrk_q) |=> irq_o);

    p_halt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata_i[1] && !wdata_i[0]) |=> halt_o);

    p_irq_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (wdata_i[3] == wdata_i[4]) && !brk_pulse_i) |=> $stable(irq_o));

    p_sema_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sema && !wr_sema) |=> sema_q);

    p_sema_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sema |=> !sema_q);

    p_unmapped_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i != ADDR_W'(STAT_ADDR) && addr_i != ADDR_W'(SEMA_ADDR))
            |-> (rdata_o == '0));
endmodule

bind cop_ctrl_regs cop_ctrl_regs_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_ADDR (STAT_ADDR),
    .SEMA_ADDR (SEMA_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .rdata_o     (rdata_o),
    .brk_pulse_i (brk_pulse_i),
    .irq_o       (irq_o),
    .halt_o      (halt_o),
    .ibrk_q      (state_q.ibrk),
    .sema_q      (state_q.sema)
);

// File: tb/cop_ctrl_regs_bench.sv
`timescale 1ns/1ps
module cop_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        brk = 1'b0;
    logic        irq, halt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model
    bit m_halt, m_brk, m_ss, m_ib, m_irq, m_sema;
    bit [7:0] m_sig;

    always #2 clk = ~clk;

    cop_ctrl_regs u_cop_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .brk_pulse_i(brk), .irq_o(irq), .halt_o(halt)
    );

    function automatic bit pair_upd(bit cur, bit c, bit s);
        if (c && !s) return 1'b0;
        if (s && !c) return 1'b1;
        return cur;
    endfunction

    function automatic logic [31:0] exp_status();
        return 32'(m_halt) | (32'(m_brk) << 1) | (32'(m_ss) << 5) |
               (32'(m_ib) << 6) | (32'(m_sig) << 7);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus, model updated to match
    task automatic cyc(bit w, logic [1:0] a, logic [31:0] d, bit b);
        bit ib_now;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; brk = b;
        ib_now = m_ib;
        if (w && a == 2'd0) begin
            m_halt = pair_upd(m_halt, d[0], d[1]);
            if (d[2]) m_brk = 1'b0;
            m_irq  = pair_upd(m_irq, d[3], d[4]);
            m_ss   = pair_upd(m_ss, d[5], d[6]);
            m_ib   = pair_upd(m_ib, d[7], d[8]);
            for (int k = 0; k < 8; k++)
                m_sig[k] = pair_upd(m_sig[k], d[9+2*k], d[10+2*k]);
        end
        if (w && a == 2'd1) m_sema = 1'b0;
        if (b) begin
            m_halt = 1'b1; m_brk = 1'b1;
            if (ib_now) m_irq = 1'b1;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; brk = 1'b0; wdata = '0;
    endtask

    // read status and compare everything visible (R10, R11)
    task automatic check_all(string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd0;
        #1;
        chk(rdata == exp_status(), {tag, " status R11"}, rdata, exp_status());
        chk(irq == m_irq, {tag, " irq"}, 32'(irq), 32'(m_irq));
        chk(halt == rdata[0], {tag, " halt_o R10"}, 32'(halt), 32'(rdata[0]));
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic read_sema(string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd1;
        #1;
        chk(rdata == 32'(m_sema), {tag, " sema read R8"}, rdata, 32'(m_sema));
        m_sema = 1'b1;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    function automatic int clr_pos(int i);
        if (i == 0) return 0;
        if (i == 1) return 3;
        return 5 + 2 * (i - 2);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_halt = 1; m_brk = 0; m_ss = 0; m_ib = 0; m_irq = 0; m_sema = 0; m_sig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check_all("R1 reset");
        chk(halt == 1'b1, "R1 halt_o", 32'(halt), 32'd1);
        read_sema("R1 reset");

        // R2/R3/R5 sweep: every pair, both start values, all four codes
        for (int i = 0; i < 12; i++) begin
            for (int init = 0; init < 2; init++) begin
                for (int code = 0; code < 4; code++) begin
                    logic [31:0] w;
                    string tag;
                    // preset flag
                    w = 32'(1) << (clr_pos(i) + (init == 1 ? 1 : 0));
                    cyc(1'b1, 2'd0, w, 1'b0);
                    w = 32'(code) << clr_pos(i);
                    cyc(1'b1, 2'd0, w, 1'b0);
                    if (i == 1) tag = "R5 irq pair";
                    else if (code == 1 || code == 2) tag = "R2 pair";
                    else tag = "R3 pair";
                    check_all(tag);
                end
            end
        end

        // R4 break clear alongside other commands
        cyc(1'b0, 2'd0, '0, 1'b1);
        check_all("R6 brk pulse");
        cyc(1'b1, 2'd0, 32'h01FF_FFFF, 1'b0);
        check_all("R4 brk clear all-ones");
        cyc(1'b0, 2'd0, '0, 1'b1);
        cyc(1'b1, 2'd0, 32'h0000_0004, 1'b0);
        check_all("R4 brk clear only");

        // R6 break with interrupt-on-break 0 and 1
        cyc(1'b1, 2'd0, 32'h0000_0088, 1'b0);   // irq clr, ibrk clr
        cyc(1'b0, 2'd0, '0, 1'b1);
        check_all("R6 brk no ibrk");
        chk(irq == 1'b0, "R6 irq stays low", 32'(irq), 32'd0);
        cyc(1'b1, 2'd0, 32'h0000_0105, 1'b0);   // ibrk set, halt clr, brk clr
        cyc(1'b0, 2'd0, '0, 1'b1);
        check_all("R6 brk with ibrk");
        chk(irq == 1'b1, "R6 irq raised", 32'(irq), 32'd1);

        // R7 break and write in same cycle
        cyc(1'b1, 2'd0, 32'h0000_0008, 1'b0);   // clear irq
        cyc(1'b1, 2'd0, 32'h0000_044D, 1'b1);   // clr halt, clr brk, clr irq, set ss, set sig0
        check_all("R7 same-cycle");
        chk(halt == 1'b1, "R7 halt wins", 32'(halt), 32'd1);

        // R8/R9 semaphore
        cyc(1'b1, 2'd1, 32'h0, 1'b0);
        read_sema("R9 after clear");
        read_sema("R8 claimed");
        read_sema("R8 still claimed");
        cyc(1'b1, 2'd1, 32'hDEAD_BEEF, 1'b0);
        read_sema("R9 any data");
        // same-cycle read and write: clear wins
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 32'h1;
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0; m_sema = 1'b0;
        read_sema("R9 write beats read");

        // R11 unmapped addresses
        for (int a = 2; a < 4; a++) begin
            cyc(1'b1, 2'(a), 32'hFFFF_FFFF, 1'b0);
            @(negedge clk);
            rd_en = 1'b1; addr = 2'(a);
            #1;
            chk(rdata == 32'h0, "R11 unmapped read", rdata, 32'h0);
            @(posedge clk); #1;
            rd_en = 1'b0;
            check_all("R11 unmapped write ignored");
        end

        // pseudo-random command stream
        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(1'b1, (lfsr[27:25] == 3'd0) ? 2'd1 : 2'd0, lfsr, lfsr[30:28] == 3'd5);
            check_all("R2 R3 R5 R7 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule